// File: doc/BRIEF.md
# Odd/Even Bus-Invert Link

This block carries a DATA_W-bit word across a parallel bus of DATA_W data lines plus two extra invert lines, with the aim of cutting coupling activity between neighbouring wires. One invert line covers the odd-numbered data lines and the other covers the even-numbered ones. For every word the encoder weighs four candidate codings against the wires as they currently stand and drives the cheapest one. The decoder at the far end undoes the coding and presents the original word.

A change of the invert pair from 01 straight to 10, or the reverse, swings two adjacent wires in opposite directions. Such a change is never driven. When the cheapest coding would need it, the word goes out in two bus cycles. The first cycle uses a neutral coding (no inversion or full inversion) and the second cycle uses the chosen coding. Words enter and leave through valid/ready handshakes. The bus wires are brought out as ports so that the coding can be watched.

Top module: `oebi_link`

## Requirements
- R1: After reset the data lines and both invert lines are 0, outValid is 0 and inReady is 1.
- R2: The invert state is written {invOdd, invEven}: 00 means none inverted, 10 means odd lines inverted, 01 means even lines inverted, and 11 means all lines inverted. Data line i carries inData[i] XOR invOdd when i is odd, and inData[i] XOR invEven when i is even. This coding is on the wires from the cycle after the word is accepted.
- R3: The wires form one chain in the order line 0 through line DATA_W-1, then invEven, then invOdd. The cost of each adjacent pair is 2 when both wires toggle in opposite directions, 1 when exactly one of them toggles, and 0 otherwise. The driven mode has the lowest total cost measured against the previous wire state.
- R4: On equal cost the mode with the lower code wins, in the order 00, 01, 10, 11.
- R5: The invert pair never changes directly between 01 and 10. If the cheapest mode would cause such a change, the first bus cycle uses mode 11 if its cost is strictly lower than that of 00, and otherwise uses 00. The cheapest mode follows in the next cycle.
- R6: During the first cycle of a two-cycle transfer, decoding the wires gives the input word, but outValid stays 0.
- R7: outData equals the accepted word. outValid rises 2 cycles after acceptance for a direct transfer, and 3 cycles after acceptance for a two-cycle transfer.
- R8: While outValid is 1 and outReady is 0, outValid and outData hold their values and inReady is 0.
- R9: In the cycle right after a word is accepted, inReady is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Source offers a word |
| inReady | output | 1 | Link accepts the offered word |
| inData | input | DATA_W | Source word |
| outValid | output | 1 | Decoded word available |
| outReady | input | 1 | Sink takes the decoded word |
| outData | output | DATA_W | Decoded word |
| busLines | output | DATA_W | Coded data wires |
| busInvOdd | output | 1 | Invert line for the odd data wires |
| busInvEven | output | 1 | Invert line for the even data wires |

## Verification
The assertions assume that the source follows the handshake, meaning it holds inValid and inData until inReady accepts them. They also assume that outReady is a plain level with no dependence on outValid. The bench drives all inputs at the falling edge. It keeps each word steady until acceptance, and it holds outReady either high or low over whole scenarios, which keeps the stimulus inside these assumptions. The bench builds its own reference model of the chain cost to predict the mode, the neutral cycle and the wire values. It also steers the wires into a known 01 state so that a two-cycle transfer is certain to occur.

// File: rtl/oebi_pkg.sv
package oebi_pkg;
  typedef logic [1:0] invModeT;   // {odd, even}

  localparam invModeT MODE_NONE = 2'b00;
  localparam invModeT MODE_EVEN = 2'b01;
  localparam invModeT MODE_ODD  = 2'b10;
  localparam invModeT MODE_ALL  = 2'b11;

  typedef struct packed {
    logic issueDirect;  // drive best mode from the input word
    logic issueInter;   // drive neutral mode and park the word
    logic issueHeld;    // drive parked word in its target mode
  } encStrobeT;
endpackage

// File: rtl/oebi_datapath.sv
module oebi_datapath
  import oebi_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  encStrobeT         strobe,
  output logic              forbidden,
  output logic [DATA_W-1:0] busLines,
  output logic [1:0]        invLines
);
  localparam int WIRE_W = DATA_W + 2;
  localparam int COST_W = $clog2(2 * (WIRE_W - 1) + 1);

  function automatic logic [DATA_W-1:0] laneMask(input logic oddLanes);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = ((i % 2) == 1) == oddLanes;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] ODD_MASK  = laneMask(1'b1);
  localparam logic [DATA_W-1:0] EVEN_MASK = laneMask(1'b0);

  function automatic logic [DATA_W-1:0] codeWord(input logic [DATA_W-1:0] d, input invModeT md);
    return d ^ (md[1] ? ODD_MASK : '0) ^ (md[0] ? EVEN_MASK : '0);
  endfunction

  function automatic logic [COST_W-1:0] chainCost(input logic [WIRE_W-1:0] prevW,
                                                  input logic [WIRE_W-1:0] nextW);
    logic [COST_W-1:0] acc;
    logic tLo, tHi;
    acc = '0;
    for (int i = 0; i < WIRE_W - 1; i++) begin
      tLo = prevW[i] ^ nextW[i];
      tHi = prevW[i+1] ^ nextW[i+1];
      if (tLo && tHi && (nextW[i] != nextW[i+1])) acc = acc + COST_W'(2);
      else if (tLo != tHi) acc = acc + COST_W'(1);
    end
    return acc;
  endfunction

  logic [DATA_W-1:0] busReg, holdData;
  invModeT           invReg, holdMode, bestMode, interMode;
  logic [COST_W-1:0] candCost [4];
  logic [COST_W-1:0] bestCost;

  for (genvar m = 0; m < 4; m++) begin : g_cand
    localparam invModeT CAND_MODE = 2'(m);
    assign candCost[m] = chainCost({invReg, busReg}, {CAND_MODE, codeWord(inData, CAND_MODE)});
  end

  always_comb begin
    bestMode = MODE_NONE;
    bestCost = candCost[0];
    for (int m = 1; m < 4; m++) begin
      if (candCost[m] < bestCost) begin
        bestCost = candCost[m];
        bestMode = 2'(m);
      end
    end
  end

  assign forbidden = ((invReg == MODE_EVEN) && (bestMode == MODE_ODD)) ||
                     ((invReg == MODE_ODD)  && (bestMode == MODE_EVEN));
  assign interMode = (candCost[3] < candCost[0]) ? MODE_ALL : MODE_NONE;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busReg   <= '0;
      invReg   <= MODE_NONE;
      holdData <= '0;
      holdMode <= MODE_NONE;
    end else if (strobe.issueDirect) begin
      busReg <= codeWord(inData, bestMode);
      invReg <= bestMode;
    end else if (strobe.issueInter) begin
      busReg   <= codeWord(inData, interMode);
      invReg   <= interMode;
      holdData <= inData;
      holdMode <= bestMode;
    end else if (strobe.issueHeld) begin
      busReg <= codeWord(holdData, holdMode);
      invReg <= holdMode;
    end
  end

  assign busLines = busReg;
  assign invLines = invReg;
endmodule

// File: rtl/oebi_ctrl.sv
module oebi_ctrl
  import oebi_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      forbidden,
  input  logic      outValid,
  input  logic      outReady,
  output logic      inReady,
  output logic      beatFinal,
  output encStrobeT strobe
);
  logic pending, canIssue, accept;

  // A final beat may go out only if the decoder slot is free at its capture edge.
  assign canIssue = !beatFinal && (!outValid || outReady);
  assign inReady  = !pending && canIssue;
  assign accept   = inValid && inReady;

  assign strobe.issueDirect = accept && !forbidden;
  assign strobe.issueInter  = accept && forbidden;
  assign strobe.issueHeld   = pending && canIssue;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending   <= 1'b0;
      beatFinal <= 1'b0;
    end else begin
      if (strobe.issueInter) pending <= 1'b1;
      else if (strobe.issueHeld) pending <= 1'b0;
      beatFinal <= strobe.issueDirect || strobe.issueHeld;
    end
  end
endmodule

// File: rtl/oebi_decoder.sv
module oebi_decoder #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busLines,
  input  logic [1:0]        invLines,
  input  logic              beatFinal,
  input  logic              outReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);
  logic [DATA_W-1:0] decoded;

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    if ((i % 2) == 1) begin : g_odd
      assign decoded[i] = busLines[i] ^ invLines[1];
    end else begin : g_even
      assign decoded[i] = busLines[i] ^ invLines[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else if (beatFinal) begin
      outValid <= 1'b1;
      outData  <= decoded;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end
endmodule

// File: rtl/oebi_link.sv
module oebi_link
  import oebi_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic [DATA_W-1:0] busLines,
  output logic              busInvOdd,
  output logic              busInvEven
);
  encStrobeT   strobe;
  logic        forbidden, beatFinal;
  logic [1:0]  invLines;

  oebi_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .forbidden(forbidden),
    .outValid(outValid), .outReady(outReady), .inReady(inReady),
    .beatFinal(beatFinal), .strobe(strobe)
  );

  oebi_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .inData(inData), .strobe(strobe),
    .forbidden(forbidden), .busLines(busLines), .invLines(invLines)
  );

  oebi_decoder #(.DATA_W(DATA_W)) dec_i (
    .clk(clk), .rstN(rstN), .busLines(busLines), .invLines(invLines),
    .beatFinal(beatFinal), .outReady(outReady), .outValid(outValid), .outData(outData)
  );

  assign busInvOdd  = invLines[1];
  assign busInvEven = invLines[0];
endmodule

// File: rtl/oebi_link_chk.sv
module oebi_link_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData,
  input logic              busInvOdd,
  input logic              busInvEven
);
  // R5
  no_opposite_invert_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(($past(busInvOdd) != $past(busInvEven)) &&
      (busInvOdd != $past(busInvOdd)) && (busInvEven != $past(busInvEven))));

  // R8
  hold_output_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R8
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  // R9
  accept_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);
endmodule

bind oebi_link oebi_link_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outData(outData),
  .busInvOdd(busInvOdd), .busInvEven(busInvEven)
);

// File: tb/oebi_link_tb.sv
module oebi_link_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [DW-1:0] inData = '0;
  logic outValid;
  logic outReady = 1'b1;
  logic [DW-1:0] outData;
  logic [DW-1:0] busLines;
  logic busInvOdd, busInvEven;

  int checks = 0;
  int failures = 0;
  int twoPhaseSeen = 0;
  bit finished = 1'b0;

  logic [DW-1:0] mBus;
  logic [1:0]    mInv;

  always #(CLK_PERIOD / 2) clk = ~clk;

  oebi_link #(.DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .busLines(busLines), .busInvOdd(busInvOdd), .busInvEven(busInvEven)
  );

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] refCode(input logic [DW-1:0] d, input logic [1:0] md);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = d[i] ^ ((i % 2 == 1) ? md[1] : md[0]);
    return r;
  endfunction

  // Signed step per wire: +1 rise, -1 fall; pair cost is |stepA - stepB|.
  function automatic int refCost(input logic [DW+1:0] a, input logic [DW+1:0] b);
    int sum = 0;
    for (int i = 0; i < DW + 1; i++) begin
      int sA = int'(b[i]) - int'(a[i]);
      int sB = int'(b[i+1]) - int'(a[i+1]);
      int df = sA - sB;
      sum += (df < 0) ? -df : df;
    end
    return sum;
  endfunction

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0; inValid = 1'b0; outReady = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mBus = '0; mInv = 2'b00;
  endtask

  task automatic testReset();
    applyReset();
    checkVal("R1 data lines", 32'(busLines), 32'h0);
    checkVal("R1 invert lines", 32'({busInvOdd, busInvEven}), 32'h0);
    checkVal("R1 outValid", 32'(outValid), 32'h0);
    checkVal("R1 inReady", 32'(inReady), 32'h1);
  endtask

  task automatic pushAndCheck(input logic [DW-1:0] d, input string tag);
    int cst [4];
    logic [1:0] best, inter;
    bit forb;
    for (int m = 0; m < 4; m++) cst[m] = refCost({mInv, mBus}, {2'(m), refCode(d, 2'(m))});
    best = 2'b00;
    for (int m = 1; m < 4; m++) if (cst[m] < cst[best]) best = 2'(m);
    forb = (mInv == 2'b01 && best == 2'b10) || (mInv == 2'b10 && best == 2'b01);
    inter = (cst[3] < cst[0]) ? 2'b11 : 2'b00;

    @(negedge clk);
    inValid = 1'b1; inData = d;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
    checkVal({tag, " R9 inReady after accept"}, 32'(inReady), 32'h0);
    if (forb) begin
      twoPhaseSeen++;
      checkVal({tag, " R5 neutral invert"}, 32'({busInvOdd, busInvEven}), 32'(inter));
      checkVal({tag, " R5 neutral lines"}, 32'(busLines), 32'(refCode(d, inter)));
      checkVal({tag, " R6 neutral decodes"}, 32'(refCode(busLines, {busInvOdd, busInvEven})), 32'(d));
      checkVal({tag, " R6 no valid on neutral"}, 32'(outValid), 32'h0);
      @(negedge clk);
      checkVal({tag, " R5 target invert"}, 32'({busInvOdd, busInvEven}), 32'(best));
      checkVal({tag, " R2 target lines"}, 32'(busLines), 32'(refCode(d, best)));
      checkVal({tag, " R7 valid not yet"}, 32'(outValid), 32'h0);
    end else begin
      checkVal({tag, " R3 mode"}, 32'({busInvOdd, busInvEven}), 32'(best));
      checkVal({tag, " R2 lines"}, 32'(busLines), 32'(refCode(d, best)));
      checkVal({tag, " R7 valid not yet"}, 32'(outValid), 32'h0);
    end
    @(negedge clk);
    checkVal({tag, " R7 outValid"}, 32'(outValid), 32'h1);
    checkVal({tag, " R7 outData"}, 32'(outData), 32'(d));
    mBus = refCode(d, best);
    mInv = best;
  endtask

  task automatic testTie();
    applyReset();
    pushAndCheck(8'hFF, "R4 tie");
    checkVal("R4 tie keeps mode 00", 32'({busInvOdd, busInvEven}), 32'h0);
  endtask

  task automatic testTwoPhase();
    applyReset();
    twoPhaseSeen = 0;
    pushAndCheck(8'h33, "R4 setup");
    pushAndCheck(8'h66, "R3 even mode");
    checkVal("R3 even mode chosen", 32'({busInvOdd, busInvEven}), 32'h1);
    pushAndCheck(8'h99, "R5 two phase");
    checkVal("R5 two-phase transfer occurred", 32'(twoPhaseSeen), 32'h1);
    checkVal("R5 final mode odd", 32'({busInvOdd, busInvEven}), 32'h2);
  endtask

  task automatic testPatterns();
    applyReset();
    pushAndCheck(8'h55, "R2 alt55");
    pushAndCheck(8'hAA, "R2 altAA");
    pushAndCheck(8'h00, "R2 zero");
    pushAndCheck(8'hFF, "R2 ones");
    pushAndCheck(8'h0F, "R3 nibble");
    pushAndCheck(8'hF0, "R3 nibble hi");
  endtask

  task automatic testRandom();
    logic [15:0] lfsr = 16'hACE1;
    applyReset();
    for (int k = 0; k < 80; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pushAndCheck(lfsr[DW-1:0] ^ lfsr[15:8], "R3 random");
    end
  endtask

  task automatic testBackPressure();
    applyReset();
    @(negedge clk);
    outReady = 1'b0;
    pushAndCheck(8'h3C, "R8 first");
    @(negedge clk);
    inValid = 1'b1; inData = 8'hC5;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      checkVal("R8 inReady low while stalled", 32'(inReady), 32'h0);
      checkVal("R8 outValid held", 32'(outValid), 32'h1);
      checkVal("R8 outData held", 32'(outData), 32'h3C);
    end
    inValid = 1'b0;
    outReady = 1'b1;
    @(negedge clk);
    checkVal("R8 drained", 32'(outValid), 32'h0);
    pushAndCheck(8'hC5, "R8 second");
  endtask

  initial begin
    testReset();
    testTie();
    testTwoPhase();
    testPatterns();
    testRandom();
    testBackPressure();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R7 watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule